// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Controller

This block turns edges on general-purpose input pins into interrupt requests. It serves sixteen lines. Line n watches pin n of one port, and a per-line selector picks that port from a bank of ports. Each selected pin passes through a two-stage synchronizer. An edge detector then compares the synchronized level with its value one clock earlier. Separate rising and falling enables decide which transitions count on each line.

A qualifying edge sets the line's pending flag. Software clears a flag by writing a one to its bit. By default a flag can only be set while its line is unmasked, so an edge that arrives while the line is masked is lost. A per-line capture option lets the flag set even while the line is masked. The request outputs always honour the mask, so a flag captured while masked raises its request as soon as software unmasks the line.

Masked pending flags drive the request outputs. Lines 0 to 4 each have their own output. Lines 5 to 9 are ORed into one shared output, and lines 10 to 15 into a second shared output. Software reaches the configuration and the flags through a word-addressed register bus with separate read and write strobes.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and all request outputs are low.
- R2: Line n follows only pin n of the port named by its 4-bit selector. Selectors sit four per word at addresses 5 to 8, and line n uses bits [4*(n%4)+3 : 4*(n%4)] of word 5+n/4. Pins of other ports have no effect on the line.
- R3: With bit n of the rising-enable word (address 1) set, a low-to-high edge on line n sets pending bit n (address 3).
- R4: With bit n of the falling-enable word (address 2) set, a high-to-low edge sets pending bit n. With both enables set, either edge sets it.
- R5: An edge on a line with neither enable set leaves its pending bit at zero.
- R6: With mask bit n (address 0, 1 = unmasked) at zero and capture bit n at zero, an edge is lost. The pending bit stays zero, and unmasking the line later raises no request.
- R7: With capture bit n (address 4) set, an edge sets pending bit n even while the line is masked. Its request stays low until mask bit n is set, and then rises at once.
- R8: A write to address 3 clears each pending bit written as one and leaves the bits written as zero unchanged.
- R9: When an edge and a clear write hit the same pending bit in the same cycle, the bit ends up set.
- R10: Request output k (k = 0..4) is high exactly when line k is pending and unmasked. Group output 0 is the OR of lines 5-9 pending and unmasked, and group output 1 is the OR of lines 10-15 pending and unmasked.
- R11: A read strobe returns the addressed register on the read-data port after the next rising clock edge. Values written read back unchanged in the low 16 bits, and the upper bits read zero.
- R12: A pin change made between clock edges sets the pending bit on the third rising clock edge after the change, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pins_i | input | 64 | Pin bank: port p, pin n at bit 16*p+n |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, updated on the edge that samples the read strobe |
| irq_direct_o | output | 5 | Per-line requests for lines 0 to 4 |
| irq_group_o | output | 2 | Shared requests: bit 0 for lines 5-9, bit 1 for lines 10-15 |

## Verification
Hardware setting a pending flag and software clearing it can land on the same flag in the same cycle. The bench provokes this on a line that has both edge enables and is already pending. It toggles the pin and then times the write-one-to-clear so that the write's clock edge is exactly the third edge after the pin change. A read-back of the flag must then show it still set, and a second, lone clear must then bring it to zero.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int ADDR_W        = 4;
  localparam int DATA_W        = 32;
  localparam int LINES_PER_SEL = 4;

  localparam logic [ADDR_W-1:0] ADR_MASK     = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_RISE     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_FALL     = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_PEND     = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CAPTURE  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_SEL_BASE = 4'd5;
endpackage

// File: rtl/pin_irq_line.sv
module pin_irq_line #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  output logic                 edge_o
);
  logic pick;
  logic s1_q, s2_q, prev_q;
  logic s1_n, s2_n, prev_n;

  always_comb begin
    pick = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_i == SEL_W'(p)) pick = pins_i[p];
    end
  end

  always_comb begin
    s1_n   = pick;
    s2_n   = s1_q;
    prev_n = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_n;
      s2_q   <= s2_n;
      prev_q <= prev_n;
    end
  end

  assign edge_o = (rise_en_i & s2_q & ~prev_q) | (fall_en_i & ~s2_q & prev_q);

  // R5
  edge_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (rise_en_i || fall_en_i));
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int SEL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_rd,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NUM_LINES-1:0]       edge_i,
  output logic [NUM_LINES-1:0]       mask_o,
  output logic [NUM_LINES-1:0]       rise_o,
  output logic [NUM_LINES-1:0]       fall_o,
  output logic [NUM_LINES-1:0]       pend_o,
  output logic [NUM_LINES*SEL_W-1:0] sel_o
);
  logic [NUM_LINES-1:0] mask_q, rise_q, fall_q, cap_q, pend_q;
  logic [NUM_LINES-1:0] mask_n, rise_n, fall_n, cap_n, pend_n;
  logic [NUM_LINES-1:0] set_v, clr_v;
  logic [SEL_W-1:0]     sel_q [NUM_LINES];
  logic [SEL_W-1:0]     sel_n [NUM_LINES];
  logic [DATA_W-1:0]    rd_q, rd_n;

  always_comb begin
    mask_n = (bus_wr && bus_addr == ADR_MASK)    ? bus_wdata[NUM_LINES-1:0] : mask_q;
    rise_n = (bus_wr && bus_addr == ADR_RISE)    ? bus_wdata[NUM_LINES-1:0] : rise_q;
    fall_n = (bus_wr && bus_addr == ADR_FALL)    ? bus_wdata[NUM_LINES-1:0] : fall_q;
    cap_n  = (bus_wr && bus_addr == ADR_CAPTURE) ? bus_wdata[NUM_LINES-1:0] : cap_q;
    clr_v  = (bus_wr && bus_addr == ADR_PEND)    ? bus_wdata[NUM_LINES-1:0] : '0;
    set_v  = edge_i & (mask_q | cap_q);
    pend_n = (pend_q & ~clr_v) | set_v;
    for (int i = 0; i < NUM_LINES; i++) begin
      sel_n[i] = sel_q[i];
      if (bus_wr && bus_addr == ADDR_W'(int'(ADR_SEL_BASE) + i / LINES_PER_SEL))
        sel_n[i] = bus_wdata[(i % LINES_PER_SEL)*SEL_W +: SEL_W];
    end
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      ADR_MASK:    rd_n[NUM_LINES-1:0] = mask_q;
      ADR_RISE:    rd_n[NUM_LINES-1:0] = rise_q;
      ADR_FALL:    rd_n[NUM_LINES-1:0] = fall_q;
      ADR_PEND:    rd_n[NUM_LINES-1:0] = pend_q;
      ADR_CAPTURE: rd_n[NUM_LINES-1:0] = cap_q;
      default: begin
        for (int i = 0; i < NUM_LINES; i++) begin
          if (bus_addr == ADDR_W'(int'(ADR_SEL_BASE) + i / LINES_PER_SEL))
            rd_n[(i % LINES_PER_SEL)*SEL_W +: SEL_W] = sel_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      cap_q  <= '0;
      pend_q <= '0;
      rd_q   <= '0;
      for (int i = 0; i < NUM_LINES; i++) sel_q[i] <= '0;
    end else begin
      mask_q <= mask_n;
      rise_q <= rise_n;
      fall_q <= fall_n;
      cap_q  <= cap_n;
      pend_q <= pend_n;
      for (int i = 0; i < NUM_LINES; i++) sel_q[i] <= sel_n[i];
      if (bus_rd) rd_q <= rd_n;
    end
  end

  assign bus_rdata = rd_q;
  assign mask_o    = mask_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign pend_o    = pend_q;

  generate
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sel
      assign sel_o[g*SEL_W +: SEL_W] = sel_q[g];
    end
  endgenerate

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_q & ~clr_v) & ~pend_q) == '0));

  // R6
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend_q & ~$past(pend_q)) & ~$past(mask_q | cap_q)) == '0));

  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_i & mask_q) & ~pend_q) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(set_v & clr_v) & ~pend_q) == '0));
endmodule

// File: rtl/pin_irq_map.sv
module pin_irq_map #(
  parameter int NUM_LINES = 16,
  parameter int N_DIRECT  = 5,
  parameter int GRP_SPLIT = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] mask_i,
  output logic [N_DIRECT-1:0]  irq_direct_o,
  output logic [1:0]           irq_group_o
);
  logic [NUM_LINES-1:0] live;
  assign live = pend_i & mask_i;

  generate
    for (genvar k = 0; k < N_DIRECT; k++) begin : g_direct
      assign irq_direct_o[k] = live[k];
    end
  endgenerate

  assign irq_group_o[0] = |live[GRP_SPLIT-1:N_DIRECT];
  assign irq_group_o[1] = |live[NUM_LINES-1:GRP_SPLIT];

  // R10
  direct_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_direct_o & ~mask_i[N_DIRECT-1:0]) == '0));

  // R10
  group_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_group_o[1] |-> (|pend_i[NUM_LINES-1:GRP_SPLIT]));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 4,
  parameter int N_DIRECT  = 5,
  parameter int GRP_SPLIT = 10
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_PORTS*NUM_LINES-1:0] pins_i,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic                           bus_wr,
  input  logic [DATA_W-1:0]              bus_wdata,
  input  logic                           bus_rd,
  output logic [DATA_W-1:0]              bus_rdata,
  output logic [N_DIRECT-1:0]            irq_direct_o,
  output logic [1:0]                     irq_group_o
);
  logic rst_a_q, rst_b_q, srst_n;
  logic [NUM_LINES-1:0]       edge_v, mask_v, rise_v, fall_v, pend_v;
  logic [NUM_LINES*SEL_W-1:0] sel_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_a_q <= 1'b0;
      rst_b_q <= 1'b0;
    end else begin
      rst_a_q <= 1'b1;
      rst_b_q <= rst_a_q;
    end
  end
  assign srst_n = rst_b_q;

  generate
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      logic [NUM_PORTS-1:0] col;
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_col
        assign col[p] = pins_i[p*NUM_LINES + n];
      end
      pin_irq_line #(.NUM_PORTS(NUM_PORTS), .SEL_W(SEL_W)) u_line (
        .clk       (clk),
        .rst_n     (srst_n),
        .pins_i    (col),
        .sel_i     (sel_v[n*SEL_W +: SEL_W]),
        .rise_en_i (rise_v[n]),
        .fall_en_i (fall_v[n]),
        .edge_o    (edge_v[n])
      );
    end
  endgenerate

  pin_irq_regs #(.NUM_LINES(NUM_LINES), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .edge_i    (edge_v),
    .mask_o    (mask_v),
    .rise_o    (rise_v),
    .fall_o    (fall_v),
    .pend_o    (pend_v),
    .sel_o     (sel_v)
  );

  pin_irq_map #(.NUM_LINES(NUM_LINES), .N_DIRECT(N_DIRECT), .GRP_SPLIT(GRP_SPLIT)) u_map (
    .clk          (clk),
    .rst_n        (srst_n),
    .pend_i       (pend_v),
    .mask_i       (mask_v),
    .irq_direct_o (irq_direct_o),
    .irq_group_o  (irq_group_o)
  );
endmodule

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins = '0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [4:0]  irq_d;
  logic [1:0]  irq_g;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  rd_item_t q[$];
  logic cap_flag = 1'b0;
  logic [15:0] mask_s = '0, rise_s = '0, fall_s = '0;

  always #10 clk = ~clk;

  pin_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rd(rd), .bus_rdata(rdata),
    .irq_direct_o(irq_d), .irq_group_o(irq_g)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) cap_flag <= rd;

  always @(negedge clk) begin
    if (cap_flag && q.size() > 0) begin
      rd_item_t it;
      it = q.pop_front();
      chk(rdata, it.exp, it.tag);
    end
  end

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    q.push_back(it);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait3();
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 9; a++) rreg(4'(a), 32'h0, "R1 reg reset");
    chk({25'h0, irq_g, irq_d}, 32'h0, "R1 irq reset");

    // R11 read-back
    wreg(4'd1, 32'hFFFF_A5C3);
    rreg(4'd1, 32'h0000_A5C3, "R11 readback rise");
    wreg(4'd1, 32'h0);
    wreg(4'd8, 32'h0000_1234);
    rreg(4'd8, 32'h0000_1234, "R11 readback sel");
    wreg(4'd8, 32'h0);

    // R3 / R12 rising edge and latency on line 0
    mask_s = 16'h0001; rise_s = 16'h0001;
    wreg(4'd0, 32'(mask_s)); wreg(4'd1, 32'(rise_s));
    pins[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(32'(irq_d), 32'h0, "R12 not yet pending after two edges");
    @(negedge clk);
    chk(32'(irq_d), 32'h1, "R12 R3 pending on third edge");
    rreg(4'd3, 32'h1, "R3 pending read");

    // R8 write-one-to-clear
    wreg(4'd3, 32'h0000_FFFE);
    rreg(4'd3, 32'h1, "R8 zero bits keep pending");
    wreg(4'd3, 32'h1);
    rreg(4'd3, 32'h0, "R8 clear");
    chk(32'(irq_d), 32'h0, "R8 irq drops after clear");

    // R5 falling edge without enable
    pins[0] = 1'b0; wait3();
    rreg(4'd3, 32'h0, "R5 no enable no pending");

    // R4 falling edge with enable
    fall_s = 16'h0001; wreg(4'd2, 32'(fall_s));
    pins[0] = 1'b1; wait3();
    wreg(4'd3, 32'h1);
    pins[0] = 1'b0; wait3();
    rreg(4'd3, 32'h1, "R4 falling sets pending");
    wreg(4'd3, 32'h1);

    // R2 port selection: line 3 from port 2
    wreg(4'd5, 32'h0000_2000);
    mask_s |= 16'h0008; rise_s |= 16'h0008;
    wreg(4'd0, 32'(mask_s)); wreg(4'd1, 32'(rise_s));
    pins[0*16+3] = 1'b1; wait3();
    chk(32'(irq_d), 32'h0, "R2 unselected port ignored");
    pins[2*16+3] = 1'b1; wait3();
    chk(32'(irq_d), 32'h8, "R2 selected port fires");
    wreg(4'd3, 32'h8);

    // R6 masked edge is lost
    rise_s |= 16'h0080; wreg(4'd1, 32'(rise_s));
    pins[7] = 1'b1; wait3();
    rreg(4'd3, 32'h0, "R6 masked edge lost");
    mask_s |= 16'h0080; wreg(4'd0, 32'(mask_s));
    @(negedge clk);
    chk(32'(irq_g), 32'h0, "R6 no request after unmask");

    // R7 capture while masked
    wreg(4'd4, 32'h0000_1000);
    rise_s |= 16'h1000; wreg(4'd1, 32'(rise_s));
    pins[12] = 1'b1; wait3();
    rreg(4'd3, 32'h1000, "R7 captured while masked");
    chk(32'(irq_g), 32'h0, "R7 request held by mask");
    mask_s |= 16'h1000; wreg(4'd0, 32'(mask_s));
    chk(32'(irq_g), 32'h2, "R7 R10 request on unmask");
    wreg(4'd3, 32'h1000);
    chk(32'(irq_g), 32'h0, "R10 group clears");

    // R10 grouping
    mask_s |= 16'h0210; rise_s |= 16'h0210;
    wreg(4'd0, 32'(mask_s)); wreg(4'd1, 32'(rise_s));
    pins[9] = 1'b1; wait3();
    chk({27'h0, irq_g, irq_d}, 32'h20, "R10 line 9 on group 0");
    pins[4] = 1'b1; wait3();
    chk({27'h0, irq_g, irq_d}, 32'h30, "R10 line 4 direct");
    wreg(4'd3, 32'h0210);

    // R9 set wins over clear in the same cycle
    mask_s |= 16'h0002; rise_s |= 16'h0002; fall_s |= 16'h0002;
    wreg(4'd0, 32'(mask_s)); wreg(4'd1, 32'(rise_s)); wreg(4'd2, 32'(fall_s));
    pins[1] = 1'b1; wait3();
    rreg(4'd3, 32'h2, "R9 pre pending");
    pins[1] = 1'b0;
    @(negedge clk); @(negedge clk);
    wreg(4'd3, 32'h2);
    rreg(4'd3, 32'h2, "R9 set wins");
    wreg(4'd3, 32'h2);
    rreg(4'd3, 32'h0, "R9 lone clear");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule